// File: doc/BRIEF.md
# Two-Wire Configuration Memory Slave

This block is the serial slave side of a configuration memory that an external programmer reads and writes over a two-wire bus. The bus has one clock line and one open-drain data line. The block samples both lines with the system clock through two-flop synchronisers. It finds start and stop conditions, checks the device select byte, and collects a 24-bit memory pointer sent as three bytes. It then either stores incoming data bytes into an internal synchronous byte array or streams bytes out of that array. The block only ever pulls the data line low (`sda_oe`); the bench or board supplies the pull-up.

Two reserved pointer values act as commands rather than storage. Any data byte written to `ERASE_ADDR` starts a whole-array erase, which fills every byte with ones. A data byte with bit 0 set written to `LOCK_ADDR` programs a read lock. While the lock is set, the array contents never appear on the line. The lock can be cleared only by an erase. While an erase sweep is running, the slave refuses its device select byte.

The controller states are ST_IDLE, ST_DEV, ST_DEV_ACK, ST_ADDR, ST_ADDR_ACK, ST_WDATA, ST_WDATA_ACK, ST_RDATA and ST_RDATA_ACK. Its transitions are:

- Any stop goes to ST_IDLE.
- Any start goes to ST_DEV. A start that arrives in the middle of a transfer is a repeated start.
- From ST_DEV, at the clock fall after the eighth bit:
  - the slave goes to ST_DEV_ACK when the select matches and no erase is running;
  - otherwise it goes to ST_IDLE.
- From ST_DEV_ACK, at the next clock fall:
  - the slave goes to ST_RDATA for a read;
  - otherwise it goes to ST_ADDR.
- From ST_ADDR, after eight bits, the slave goes to ST_ADDR_ACK.
- From ST_ADDR_ACK:
  - the slave goes back to ST_ADDR for the first two pointer bytes;
  - it goes to ST_WDATA after the third.
- From ST_WDATA, after eight bits, the slave goes to ST_WDATA_ACK.
- From ST_WDATA_ACK:
  - the slave goes back to ST_WDATA when it accepted the byte;
  - otherwise it goes to ST_IDLE.
- From ST_RDATA, after eight bits, the slave goes to ST_RDATA_ACK.
- From ST_RDATA_ACK:
  - the slave goes back to ST_RDATA when the master pulled the line low;
  - otherwise it goes to ST_IDLE.

Top module: `cfgmem_twi_slave`

## Requirements
- R1: A falling data line while the clock is high starts a transfer. A rising data line while the clock is high ends it and returns the slave to idle. A byte clocked after a stop, without a new start, gets no acknowledge.
- R2: The device select byte is sent most significant bit first. Its upper seven bits must be 1010011, which gives 0xA6 for a write and 0xA7 for a read, with bit 0 set meaning read. On a match the slave pulls the line low in the acknowledge bit. On any other value it leaves the line high and ignores the bus until the next start.
- R3: The memory pointer is three bytes: most significant first, middle second, least significant third. Each byte is sent most significant bit first and is acknowledged. The array is indexed by the low `ADDR_W` bits of the pointer.
- R4: Data bytes travel least significant bit first in both directions.
- R5: Each data byte written to a non-reserved pointer is stored at the pointer, acknowledged, and the pointer then advances by one.
- R6: A read that begins with 0xA7 straight after a start returns bytes from the current pointer.
- R7: A random read is a write of the three pointer bytes, then a repeated start and 0xA7. It returns bytes starting at the pointer just sent.
- R8: In a read, the slave sends the next byte from an advanced pointer for as long as the master pulls the line low after each byte. A high acknowledge ends the transfer, and the slave releases the line.
- R9: The pointer wraps from the top of the array (2^ADDR_W - 1) to 0, in both reads and writes.
- R10: A data byte written to pointer `ERASE_ADDR` (default 0xFFFFFF) sets every array byte to 0xFF. The value of that byte is irrelevant. Neither that write nor a write to `LOCK_ADDR` changes any array byte.
- R11: For `max(ERASE_CYCLES, 2^ADDR_W)` cycles after an erase starts, the device select byte is not acknowledged.
- R12: A data byte with bit 0 set, written to `LOCK_ADDR` (default 0xFFFFFE), locks reads. While locked, read bits leave the line released, so they appear as 0xFF. Writing a byte with bit 0 clear does not unlock. Only an erase clears the lock.
- R13: After reset the slave releases the data line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level, as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The bench builds the slave with `ADDR_W` = 4, which gives a 16-byte array. With so few bytes, a four-byte burst crosses the wrap from 15 to 0 in both directions. It sets `ERASE_CYCLES` to 400. That window is long enough for the bench to finish a stop, a new start and a full device select byte while the sweep is still running, so the refused acknowledge can be seen at the pins. The reserved pointers keep their default values. Their low four bits (14 and 15) fall on array bytes that hold known data, so a stray store into the array would show up in a later read.

// File: rtl/cfgmem_twi_pkg.sv
package cfgmem_twi_pkg;

    localparam int MADDR_W = 24;

    // upper seven bits of the device select byte; bit 0 is the read flag
    localparam logic [6:0] DEV_SEL = 7'b1010011;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK
    } twi_state_e;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    // the synchronised level sits at index STAGES-1; index STAGES is one cycle older
    logic [STAGES:0] scl_sh;
    logic [STAGES:0] sda_sh;
    logic scl_now, scl_old, sda_old;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[STAGES-1:0], scl_i};
            sda_sh <= {sda_sh[STAGES-1:0], sda_i};
        end
    end

    assign scl_now   = scl_sh[STAGES-1];
    assign scl_old   = scl_sh[STAGES];
    assign sda_s     = sda_sh[STAGES-1];
    assign sda_old   = sda_sh[STAGES];
    assign scl_rise  = scl_now & ~scl_old;
    assign scl_fall  = ~scl_now & scl_old;
    assign start_det = scl_now & scl_old & ~sda_s & sda_old;
    assign stop_det  = scl_now & scl_old & sda_s & ~sda_old;

endmodule

// File: rtl/cfgmem_store.sv
module cfgmem_store #(
    parameter int ADDR_W       = 10,
    parameter int ERASE_CYCLES = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              erase_go,
    input  logic              lock_set,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              locked
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int SPAN  = (ERASE_CYCLES > DEPTH) ? ERASE_CYCLES : DEPTH;
    localparam int CW    = $clog2(SPAN + 1);

    logic [7:0]        mem [DEPTH];
    logic [CW-1:0]     ecnt;
    logic              sweep_on;
    logic [ADDR_W-1:0] sweep_addr;

    assign busy       = (ecnt != '0);
    assign sweep_on   = busy && (ecnt <= CW'(DEPTH));
    assign sweep_addr = ADDR_W'(ecnt - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n)
            ecnt <= '0;
        else if (erase_go && !busy)
            ecnt <= CW'(SPAN);
        else if (busy)
            ecnt <= ecnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            locked <= 1'b0;
        else if (erase_go)
            locked <= 1'b0;
        else if (lock_set)
            locked <= 1'b1;
    end

    // array: the erase sweep has priority over a store
    always_ff @(posedge clk) begin
        if (sweep_on)
            mem[sweep_addr] <= 8'hFF;
        else if (wr_en)
            mem[addr] <= wr_data;
        rd_data <= mem[addr];
    end

endmodule

// File: rtl/cfgmem_twi_slave.sv
module cfgmem_twi_slave
    import cfgmem_twi_pkg::*;
#(
    parameter int          ADDR_W       = 10,
    parameter int          ERASE_CYCLES = 2048,
    parameter logic [23:0] ERASE_ADDR   = 24'hFFFFFF,
    parameter logic [23:0] LOCK_ADDR    = 24'hFFFFFE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);

    localparam int PW = MADDR_W - ADDR_W;

    twi_state_e       state, nxt;
    logic [3:0]       bitcnt;
    logic [7:0]       sh;
    logic [1:0]       aidx;
    logic [MADDR_W-1:0] ptr, ptr_inc;
    logic             rw, ack_q, mack;
    logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic             byte_done, wbyte, is_erase, is_lock;
    logic             wr_en, erase_go, lock_set, busy, locked;
    logic [7:0]       rd_data;

    twi_line_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    cfgmem_store #(.ADDR_W(ADDR_W), .ERASE_CYCLES(ERASE_CYCLES)) u_store (
        .clk(clk), .rst_n(rst_n), .addr(ptr[ADDR_W-1:0]), .wr_en(wr_en),
        .wr_data(sh), .erase_go(erase_go), .lock_set(lock_set),
        .rd_data(rd_data), .busy(busy), .locked(locked)
    );

    assign byte_done = scl_fall && (bitcnt == 4'd8);
    assign ptr_inc   = {{PW{1'b0}}, ptr[ADDR_W-1:0] + 1'b1};
    assign is_erase  = (ptr == ERASE_ADDR);
    assign is_lock   = (ptr == LOCK_ADDR);
    assign wbyte     = (state == ST_WDATA) && byte_done && !start_det && !stop_det && !busy;
    assign wr_en     = wbyte && !is_erase && !is_lock;
    assign erase_go  = wbyte && is_erase;
    assign lock_set  = wbyte && is_lock && sh[0];

    // next state
    always_comb begin
        nxt = state;
        if (stop_det)
            nxt = ST_IDLE;
        else if (start_det)
            nxt = ST_DEV;
        else begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_DEV:       if (byte_done) nxt = (sh[7:1] == DEV_SEL && !busy) ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK:   if (scl_fall)  nxt = rw ? ST_RDATA : ST_ADDR;
                ST_ADDR:      if (byte_done) nxt = ST_ADDR_ACK;
                ST_ADDR_ACK:  if (scl_fall)  nxt = (aidx == 2'd2) ? ST_WDATA : ST_ADDR;
                ST_WDATA:     if (byte_done) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall)  nxt = ack_q ? ST_WDATA : ST_IDLE;
                ST_RDATA:     if (scl_fall && bitcnt == 4'd7) nxt = ST_RDATA_ACK;
                ST_RDATA_ACK: if (scl_fall)  nxt = mack ? ST_RDATA : ST_IDLE;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // shift, count and pointer datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitcnt <= '0;
            sh     <= '0;
            aidx   <= '0;
            ptr    <= '0;
            rw     <= 1'b0;
            ack_q  <= 1'b0;
            mack   <= 1'b0;
        end else if (start_det || stop_det) begin
            bitcnt <= '0;
        end else begin
            unique case (state)
                ST_DEV, ST_ADDR: begin
                    if (scl_rise) begin
                        sh     <= {sh[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end
                    if (byte_done && state == ST_DEV) rw <= sh[0];
                    if (byte_done && state == ST_ADDR) begin
                        unique case (aidx)
                            2'd0:    ptr[23:16] <= sh;
                            2'd1:    ptr[15:8]  <= sh;
                            default: ptr[7:0]   <= sh;
                        endcase
                    end
                end
                ST_DEV_ACK: if (scl_fall) begin
                    bitcnt <= '0;
                    aidx   <= '0;
                    if (rw) sh <= rd_data;
                end
                ST_ADDR_ACK: if (scl_fall) begin
                    bitcnt <= '0;
                    aidx   <= aidx + 2'd1;
                end
                ST_WDATA: begin
                    if (scl_rise) begin
                        sh     <= {sda_s, sh[7:1]};
                        bitcnt <= bitcnt + 4'd1;
                    end
                    if (byte_done) begin
                        ack_q <= !busy;
                        if (wr_en) ptr <= ptr_inc;
                    end
                end
                ST_WDATA_ACK: if (scl_fall) bitcnt <= '0;
                ST_RDATA: if (scl_fall) begin
                    sh     <= {1'b1, sh[7:1]};
                    bitcnt <= bitcnt + 4'd1;
                    if (bitcnt == 4'd7) ptr <= ptr_inc;
                end
                ST_RDATA_ACK: begin
                    if (scl_rise) mack <= !sda_s;
                    if (scl_fall) begin
                        bitcnt <= '0;
                        sh     <= rd_data;
                    end
                end
                default: ;
            endcase
        end
    end

    // line drive
    always_comb begin
        unique case (state)
            ST_DEV_ACK, ST_ADDR_ACK: sda_oe = 1'b1;
            ST_WDATA_ACK:            sda_oe = ack_q;
            ST_RDATA:                sda_oe = !sh[0] && !locked;
            default:                 sda_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/cfgmem_twi_checker.sv
module cfgmem_twi_checker
    import cfgmem_twi_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input twi_state_e state,
    input logic       sda_oe,
    input logic       stop_det,
    input logic       erase_go,
    input logic       busy,
    input logic       locked
);

    a_r1_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE));

    a_r2_oe_only_ack_or_read: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (state inside {ST_DEV_ACK, ST_ADDR_ACK, ST_WDATA_ACK, ST_RDATA}));

    a_r10_erase_busy: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |=> busy);

    a_r11_busy_no_dev_ack: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (state != ST_DEV_ACK));

    a_r12_lock_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && state == ST_RDATA) |-> !sda_oe);

    a_r12_erase_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |=> !locked);

endmodule

bind cfgmem_twi_slave cfgmem_twi_checker u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .sda_oe(sda_oe),
    .stop_det(stop_det), .erase_go(erase_go), .busy(busy), .locked(locked)
);

// File: tb/sim_cfgmem_twi_slave.sv
module sim_cfgmem_twi_slave;

    localparam int CLK_PERIOD = 10;
    localparam int H  = 8;
    localparam int AW = 4;
    localparam int EC = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic sda_bus;

    assign sda_bus = m_sda & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgmem_twi_slave #(.ADDR_W(AW), .ERASE_CYCLES(EC)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe)
    );

    int    exp_q[$];
    string tag_q[$];
    int    act_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;

    logic [7:0] model [16];
    bit         locked_m = 0;
    int         ptr_m = 0;

    // monitor: pops results as the bus produces them
    always @(negedge clk) begin
        if (act_q.size() > 0 && exp_q.size() > 0) begin
            int    a;
            int    e;
            string t;
            a = act_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (a != e) begin
                n_bad++;
                $display("FAIL %s: actual %0h expected %0h", t, a, e);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_item(input string t, input int e);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic observe(input int a);
        act_q.push_back(a);
    endtask

    task automatic bus_start();
        m_sda = 1; tick(H); m_scl = 1; tick(H); m_sda = 0; tick(H); m_scl = 0; tick(4);
    endtask

    task automatic bus_stop();
        m_sda = 0; tick(H); m_scl = 1; tick(H); m_sda = 1; tick(H);
    endtask

    task automatic send_bit(input logic v);
        m_sda = v; tick(H); m_scl = 1; tick(H); m_scl = 0; tick(4);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit lsb, input string t, input int exp_ack);
        for (int i = 0; i < 8; i++) send_bit(lsb ? b[i] : b[7-i]);
        expect_item(t, exp_ack);
        m_sda = 1; tick(H); m_scl = 1; tick(H/2);
        observe(int'(sda_bus == 1'b0));
        tick(H/2); m_scl = 0; tick(4);
    endtask

    task automatic read_byte(input string t, input int expv, input bit ack);
        logic [7:0] r;
        expect_item(t, expv);
        m_sda = 1;
        for (int i = 0; i < 8; i++) begin
            tick(H); m_scl = 1; tick(H/2);
            r[i] = sda_bus;
            tick(H/2); m_scl = 0; tick(4);
        end
        observe(int'(r));
        send_bit(ack ? 1'b0 : 1'b1);
        m_sda = 1;
    endtask

    task automatic send_ptr(input logic [23:0] a, input string t);
        for (int k = 0; k < 3; k++) send_byte(a[23-8*k -: 8], 0, {t, " addr ack"}, 1);
    endtask

    task automatic write_burst(input logic [23:0] a, input logic [31:0] d, input int n, input string t);
        bus_start();
        send_byte(8'hA6, 0, {t, " dev ack"}, 1);
        send_ptr(a, t);
        for (int i = 0; i < n; i++) send_byte(d[8*i +: 8], 1, {t, " data ack"}, 1);
        bus_stop();
        if (a == 24'hFFFFFF) begin
            for (int j = 0; j < 16; j++) model[j] = 8'hFF;
            locked_m = 0;
        end else if (a == 24'hFFFFFE) begin
            if (d[0]) locked_m = 1;
        end else begin
            for (int i = 0; i < n; i++) model[(int'(a[3:0]) + i) % 16] = d[8*i +: 8];
            ptr_m = (int'(a[3:0]) + n) % 16;
        end
    endtask

    task automatic read_tail(input int n, input string t);
        for (int i = 0; i < n; i++)
            read_byte({t, " byte"}, locked_m ? 8'hFF : int'(model[(ptr_m + i) % 16]), i < n - 1);
        ptr_m = (ptr_m + n) % 16;
        tick(H);
        expect_item({t, " R8 released"}, 1);
        observe(int'(sda_bus));
        bus_stop();
    endtask

    task automatic read_random(input logic [23:0] a, input int n, input string t);
        bus_start();
        send_byte(8'hA6, 0, {t, " dev ack"}, 1);
        send_ptr(a, t);
        bus_start();
        send_byte(8'hA7, 0, {t, " read dev ack"}, 1);
        ptr_m = int'(a[3:0]);
        read_tail(n, t);
    endtask

    task automatic read_current(input int n, input string t);
        bus_start();
        send_byte(8'hA7, 0, {t, " read dev ack"}, 1);
        read_tail(n, t);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        tick(5);
        expect_item("R13 line released in reset", 1);
        observe(int'(sda_bus));
        rst_n = 1;
        tick(5);

        // erase first, then probe while the sweep runs
        write_burst(24'hFFFFFF, 32'h0000_0000, 1, "R10 erase");
        bus_start();
        send_byte(8'hA6, 0, "R11 busy select nack", 0);
        bus_stop();
        tick(EC + 50);

        // bad select, then bytes ignored until a start
        bus_start();
        send_byte(8'hA4, 0, "R2 bad select nack", 0);
        send_byte(8'hA6, 0, "R2 ignored until start", 0);
        bus_stop();
        send_byte(8'hA6, 0, "R1 no start after stop nack", 0);
        bus_stop();

        write_burst(24'h000002, 32'h003D_C612, 3, "R5 R4 write");
        read_random(24'h000001, 4, "R7 R8 R4 random sequential");

        write_burst(24'h00000E, 32'h074C_839E, 4, "R9 write wrap");
        read_current(2, "R6 current");
        read_random(24'h00000F, 3, "R9 read wrap");

        write_burst(24'h0A0306, 32'h0000_006B, 1, "R3 pointer order");
        read_random(24'h000006, 1, "R3 pointer order");

        write_burst(24'hFFFFFE, 32'h0000_0000, 1, "R12 lock zero");
        read_random(24'h00000E, 2, "R10 R12 reserved no store");

        write_burst(24'hFFFFFE, 32'h0000_0001, 1, "R12 set lock");
        read_random(24'h000002, 2, "R12 locked read");
        write_burst(24'hFFFFFE, 32'h0000_0000, 1, "R12 clear attempt");
        read_random(24'h000002, 1, "R12 still locked");

        write_burst(24'hFFFFFF, 32'h0000_0055, 1, "R10 erase unlock");
        tick(EC + 50);
        write_burst(24'h000002, 32'h0000_005A, 1, "R12 write after erase");
        read_random(24'h000002, 1, "R12 unlocked read");
        read_random(24'h000003, 1, "R10 erased byte");

        tick(20);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule